// File: doc/BRIEF.md
# Cache Line Address Monitor Wakeup

This unit lets one core sleep until a chosen cache line is written by another agent. The core first arms the monitor with the address it cares about. It then issues a wait with the translated physical address. The unit keeps the line-aligned form of that address and holds the core in a waiting state. While the core waits, the unit watches every coherence invalidation or eviction notice. When a notice names the stored line, the unit wakes the core with a single-cycle pulse.

Other wake sources, such as interrupts, can raise a pending flag. If that flag is already set when the next wait arrives, the wait returns at once instead of sleeping, and the flag is consumed. The unit also reports the length of the monitored access: the access is cut short so that it ends at the first line boundary after the armed address.

Top module: `line_wake_unit`

## Requirements
- R1: After reset, `armed_o`, `waiting_o`, `pending_o`, `wake_o` and `skip_o` are 0, and `line_addr_o` is 0.
- R2: When `arm_vld` is high, the next cycle shows `armed_o`=1, `mon_vaddr_o`=`arm_vaddr` and `line_addr_o`=0. A wait in the same cycle as an arm is ignored.
- R3: A wait that puts the core to sleep stores `wait_paddr` with its low log2(LINE_BYTES) bits cleared (bits [5:0] at the default of 64 bytes). The stored value appears on `line_addr_o` in the next cycle.
- R4: A wait that arrives while `pending_o`=0 sets `waiting_o` in the next cycle.
- R5: A wait that arrives while `pending_o`=1 has these effects:
  - `pending_o` is cleared.
  - `waiting_o` and `line_addr_o` are left unchanged.
  - `skip_o` pulses high for exactly the next cycle.
- R6: An invalidation is a match when `inv_paddr` equals `line_addr_o` exactly while `armed_o`=1 and `waiting_o`=1. A match produces `wake_o`=1 for exactly the next cycle and clears `waiting_o`.
- R7: A wakeup leaves `armed_o` unchanged.
- R8: `mon_len_o` equals LINE_BYTES minus (`mon_vaddr_o` mod LINE_BYTES) when that offset is nonzero, and equals LINE_BYTES when the armed address is line-aligned.
- R9: An invalidation with a mismatched address, or one that arrives while the unit is not armed or not waiting, produces no wakeup and leaves `waiting_o` unchanged.
- R10: An invalidation in the same cycle as `arm_vld` produces no wakeup.
- R11: `wake_set` sets `pending_o` in the next cycle. If `wake_set` arrives in the same cycle as a wait that consumes the flag, the flag stays set.
- R12: When a wait and an invalidation arrive in the same cycle, the invalidation is judged against the state before that cycle, and the wait is applied after it. A match therefore pulses `wake_o`, and the sleeping wait still sets `waiting_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| arm_vld | input | 1 | Arm request |
| arm_vaddr | input | AW | Virtual address to monitor |
| wait_vld | input | 1 | Wait request |
| wait_paddr | input | AW | Translated physical address of the wait |
| inv_vld | input | 1 | Invalidation or eviction notice valid |
| inv_paddr | input | AW | Physical line address of the notice |
| wake_set | input | 1 | Other wake source sets the pending flag |
| armed_o | output | 1 | Monitor armed |
| waiting_o | output | 1 | Core is sleeping on the line |
| pending_o | output | 1 | Wakeup pending for the next wait |
| wake_o | output | 1 | Single-cycle wakeup pulse |
| skip_o | output | 1 | Single-cycle pulse: the last wait returned without sleeping |
| line_addr_o | output | AW | Stored line-aligned physical address |
| mon_vaddr_o | output | AW | Stored armed virtual address |
| mon_len_o | output | log2(LINE_BYTES)+1 | Monitored access length, trimmed at the line boundary |

## Verification
A wakeup needs the right sequence on three ports: an arm, then a sleeping wait, then a notice whose address equals the stored line exactly. Fully random addresses would almost never hit that sequence. The stimulus therefore draws wait and invalidation addresses from four lines, with small byte offsets. Most invalidations either reuse the current line or differ only in offset bits, which must not match. The hardest cases are collisions in a single cycle (wait with invalidation, arm with invalidation, and wait with `wake_set`). Directed sequences force each of these collisions, and the random phase keeps producing them at a high request density.

// File: rtl/mwu_pkg.sv
package mwu_pkg;
    localparam int unsigned DEF_AW         = 48;
    localparam int unsigned DEF_LINE_BYTES = 64;
endpackage

// File: rtl/mwu_line_align.sv
module mwu_line_align #(
    parameter int unsigned AW         = mwu_pkg::DEF_AW,
    parameter int unsigned LINE_BYTES = mwu_pkg::DEF_LINE_BYTES
) (
    input  logic [AW-1:0] addr_i,
    output logic [AW-1:0] base_o
);
    localparam logic [AW-1:0] OFS_MASK = AW'(LINE_BYTES - 1);

    always_comb begin
        base_o = addr_i & ~OFS_MASK;
    end
endmodule

// File: rtl/mwu_span_trim.sv
module mwu_span_trim #(
    parameter int unsigned LINE_BYTES = mwu_pkg::DEF_LINE_BYTES,
    localparam int unsigned LW        = $clog2(LINE_BYTES)
) (
    input  logic [LW-1:0] ofs_i,
    output logic [LW:0]   len_o
);
    localparam logic [LW:0] FULL = (LW+1)'(LINE_BYTES);

    always_comb begin
        if (ofs_i == '0) begin
            len_o = FULL;
        end else begin
            len_o = FULL - {1'b0, ofs_i};
        end
    end
endmodule

// File: rtl/mwu_snoop_cmp.sv
module mwu_snoop_cmp #(
    parameter int unsigned AW = mwu_pkg::DEF_AW
) (
    input  logic          inv_vld_i,
    input  logic [AW-1:0] inv_paddr_i,
    input  logic          armed_i,
    input  logic          waiting_i,
    input  logic [AW-1:0] line_i,
    output logic          hit_o
);
    always_comb begin
        hit_o = inv_vld_i && armed_i && waiting_i && (inv_paddr_i == line_i);
    end
endmodule

// File: rtl/line_wake_unit.sv
module line_wake_unit #(
    parameter int unsigned AW         = mwu_pkg::DEF_AW,
    parameter int unsigned LINE_BYTES = mwu_pkg::DEF_LINE_BYTES,
    localparam int unsigned LW        = $clog2(LINE_BYTES)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          arm_vld,
    input  logic [AW-1:0] arm_vaddr,
    input  logic          wait_vld,
    input  logic [AW-1:0] wait_paddr,
    input  logic          inv_vld,
    input  logic [AW-1:0] inv_paddr,
    input  logic          wake_set,
    output logic          armed_o,
    output logic          waiting_o,
    output logic          pending_o,
    output logic          wake_o,
    output logic          skip_o,
    output logic [AW-1:0] line_addr_o,
    output logic [AW-1:0] mon_vaddr_o,
    output logic [LW:0]   mon_len_o
);
    typedef struct packed {
        logic          armed;
        logic          waiting;
        logic          pend;
        logic          wake;
        logic          skip;
        logic [AW-1:0] line;
        logic [AW-1:0] vaddr;
    } mon_state_t;

    mon_state_t st_d, st_q;
    logic [AW-1:0] wait_base;
    logic          snoop_hit;

    mwu_line_align #(.AW(AW), .LINE_BYTES(LINE_BYTES)) u_align (
        .addr_i (wait_paddr),
        .base_o (wait_base)
    );

    mwu_span_trim #(.LINE_BYTES(LINE_BYTES)) u_trim (
        .ofs_i (st_q.vaddr[LW-1:0]),
        .len_o (mon_len_o)
    );

    mwu_snoop_cmp #(.AW(AW)) u_cmp (
        .inv_vld_i   (inv_vld),
        .inv_paddr_i (inv_paddr),
        .armed_i     (st_q.armed),
        .waiting_i   (st_q.waiting),
        .line_i      (st_q.line),
        .hit_o       (snoop_hit)
    );

    always_comb begin
        st_d      = st_q;
        st_d.wake = 1'b0;
        st_d.skip = 1'b0;
        if (wake_set) begin
            st_d.pend = 1'b1;
        end
        if (arm_vld) begin
            st_d.armed = 1'b1;
            st_d.vaddr = arm_vaddr;
            st_d.line  = '0;
        end else begin
            if (snoop_hit) begin
                st_d.waiting = 1'b0;
                st_d.wake    = 1'b1;
            end
            if (wait_vld) begin
                if (st_q.pend) begin
                    st_d.pend = wake_set;
                    st_d.skip = 1'b1;
                end else begin
                    st_d.line    = wait_base;
                    st_d.waiting = 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign armed_o     = st_q.armed;
    assign waiting_o   = st_q.waiting;
    assign pending_o   = st_q.pend;
    assign wake_o      = st_q.wake;
    assign skip_o      = st_q.skip;
    assign line_addr_o = st_q.line;
    assign mon_vaddr_o = st_q.vaddr;

    // R2: an arm leaves the unit armed with a cleared line address
    p_arm_clears_line_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $past(arm_vld) |-> (armed_o && line_addr_o == '0));

    // R4: waiting only rises after a wait that found no pending wakeup
    p_sleep_entry_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(waiting_o) |-> $past(wait_vld && !arm_vld && !pending_o));

    // R5: a skip pulse follows a wait that consumed the pending flag
    p_skip_cause_r5: assert property (@(posedge clk) disable iff (!rst_n)
        skip_o |-> $past(wait_vld && !arm_vld && pending_o));

    // R6 / R10: a wake pulse follows an exact match while armed and waiting, without an arm
    p_wake_cause_r6: assert property (@(posedge clk) disable iff (!rst_n)
        wake_o |-> $past(inv_vld && !arm_vld && armed_o && waiting_o
                         && inv_paddr == line_addr_o));

    // R7: a wakeup never disarms the monitor
    p_wake_keeps_arm_r7: assert property (@(posedge clk) disable iff (!rst_n)
        wake_o |-> armed_o);

    // R11: wake_set is visible as pending in the next cycle
    p_pend_set_r11: assert property (@(posedge clk) disable iff (!rst_n)
        $past(wake_set) |-> pending_o);
endmodule

// File: tb/line_wake_unit_tb_top.sv
module line_wake_unit_tb_top;
    localparam int unsigned AW   = 48;
    localparam int unsigned LINE = 64;
    localparam int unsigned LW   = $clog2(LINE);

    logic          clk = 1'b0;
    logic          rst_n;
    logic          arm_vld, wait_vld, inv_vld, wake_set;
    logic [AW-1:0] arm_vaddr, wait_paddr, inv_paddr;
    logic          armed_o, waiting_o, pending_o, wake_o, skip_o;
    logic [AW-1:0] line_addr_o, mon_vaddr_o;
    logic [LW:0]   mon_len_o;

    int unsigned n_chk  = 0;
    int unsigned n_fail = 0;
    bit          done   = 1'b0;

    typedef struct {
        bit          armed, waiting, pend, wake, skip;
        logic [AW-1:0] line, vaddr;
    } ref_t;

    ref_t m;

    line_wake_unit #(.AW(AW), .LINE_BYTES(LINE)) dut_i (
        .clk(clk), .rst_n(rst_n),
        .arm_vld(arm_vld), .arm_vaddr(arm_vaddr),
        .wait_vld(wait_vld), .wait_paddr(wait_paddr),
        .inv_vld(inv_vld), .inv_paddr(inv_paddr),
        .wake_set(wake_set),
        .armed_o(armed_o), .waiting_o(waiting_o), .pending_o(pending_o),
        .wake_o(wake_o), .skip_o(skip_o), .line_addr_o(line_addr_o),
        .mon_vaddr_o(mon_vaddr_o), .mon_len_o(mon_len_o)
    );

    always #5 clk = ~clk;

    function automatic logic [AW-1:0] align_line(logic [AW-1:0] a);
        return {a[AW-1:LW], {LW{1'b0}}};
    endfunction

    function automatic logic [LW:0] exp_len(logic [AW-1:0] va);
        int unsigned ofs = int'(va) % LINE;
        return (ofs == 0) ? (LW+1)'(LINE) : (LW+1)'(LINE - ofs);
    endfunction

    function automatic ref_t ref_next(ref_t s);
        ref_t n = s;
        bit hit;
        n.wake = 0;
        n.skip = 0;
        if (wake_set) n.pend = 1;
        if (arm_vld) begin
            n.armed = 1;
            n.vaddr = arm_vaddr;
            n.line  = '0;
        end else begin
            hit = inv_vld && s.armed && s.waiting && (inv_paddr == s.line);
            if (hit) begin
                n.waiting = 0;
                n.wake    = 1;
            end
            if (wait_vld) begin
                if (s.pend) begin
                    n.pend = wake_set;
                    n.skip = 1;
                end else begin
                    n.line    = align_line(wait_paddr);
                    n.waiting = 1;
                end
            end
        end
        return n;
    endfunction

    task automatic chk(string tag, logic [AW-1:0] act, logic [AW-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s act=%0h exp=%0h t=%0t", tag, act, exp, $time);
        end
    endtask

    task automatic compare_all();
        chk("R2 armed",         AW'(armed_o),   AW'(m.armed));
        chk("R2 mon_vaddr",     mon_vaddr_o,    m.vaddr);
        chk("R3 line_addr",     line_addr_o,    m.line);
        chk("R4/R9 waiting",    AW'(waiting_o), AW'(m.waiting));
        chk("R5 skip",          AW'(skip_o),    AW'(m.skip));
        chk("R6/R10/R12 wake",  AW'(wake_o),    AW'(m.wake));
        chk("R11 pending",      AW'(pending_o), AW'(m.pend));
        chk("R8 mon_len",       AW'(mon_len_o), AW'(exp_len(m.vaddr)));
    endtask

    task automatic idle_in();
        arm_vld = 0; wait_vld = 0; inv_vld = 0; wake_set = 0;
        arm_vaddr = '0; wait_paddr = '0; inv_paddr = '0;
    endtask

    // inputs already driven at a falling edge; advance one cycle and check
    task automatic step();
        m = ref_next(m);
        @(posedge clk);
        @(negedge clk);
        compare_all();
        idle_in();
    endtask

    task automatic do_arm(logic [AW-1:0] va);
        arm_vld = 1; arm_vaddr = va; step();
    endtask
    task automatic do_wait(logic [AW-1:0] pa);
        wait_vld = 1; wait_paddr = pa; step();
    endtask
    task automatic do_inv(logic [AW-1:0] pa);
        inv_vld = 1; inv_paddr = pa; step();
    endtask

    initial begin
        int unsigned cyc = 0;
        while (!done && cyc < 100000) begin
            @(posedge clk);
            cyc++;
        end
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog act=hung exp=finished");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        logic [AW-1:0] lines [4];
        void'($urandom(32'h5eed_1234));
        idle_in();
        rst_n = 0;
        m = '{default: '0};
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1;
        // R1: reset state
        compare_all();
        chk("R1 reset wake", AW'(wake_o), '0);

        // R8: trimmed length, unaligned and aligned
        do_arm(48'h0000_1234_5678);
        chk("R8 len unaligned", AW'(mon_len_o), AW'(64 - 'h38));
        do_arm(48'h0000_0000_1000);
        chk("R8 len aligned", AW'(mon_len_o), AW'(64));
        // R3/R4: sleeping wait stores the aligned line
        do_wait(48'h0000_00AB_CD7F);
        chk("R3 aligned line", line_addr_o, 48'h0000_00AB_CD40);
        // R9: offset-only difference does not match
        do_inv(48'h0000_00AB_CD41);
        chk("R9 mismatch no wake", AW'(wake_o), '0);
        // R6/R7: exact match wakes
        do_inv(48'h0000_00AB_CD40);
        chk("R6 wake pulse", AW'(wake_o), AW'(1));
        chk("R7 armed kept", AW'(armed_o), AW'(1));
        step();
        chk("R6 single pulse", AW'(wake_o), '0);
        // R9: not waiting any more
        do_inv(48'h0000_00AB_CD40);
        chk("R9 not waiting", AW'(wake_o), '0);
        // R11/R5: pending consumed by next wait
        wake_set = 1; step();
        chk("R11 pending set", AW'(pending_o), AW'(1));
        do_wait(48'h0000_0000_2000);
        chk("R5 skip", AW'(skip_o), AW'(1));
        chk("R5 no sleep", AW'(waiting_o), '0);
        // R11: wake_set with consuming wait keeps flag
        wake_set = 1; step();
        wake_set = 1; wait_vld = 1; wait_paddr = 48'h40; step();
        chk("R11 pend kept", AW'(pending_o), AW'(1));
        do_wait(48'h80);  // consumes
        // R10: arm with matching invalidation
        do_wait(48'h0000_0000_3000);
        arm_vld = 1; arm_vaddr = 48'h10; inv_vld = 1; inv_paddr = 48'h3000; step();
        chk("R10 arm wins", AW'(wake_o), '0);
        // R12: wait and matching invalidation together
        do_wait(48'h0000_0000_5000);
        inv_vld = 1; inv_paddr = 48'h5000; wait_vld = 1; wait_paddr = 48'h6010; step();
        chk("R12 wake", AW'(wake_o), AW'(1));
        chk("R12 still waiting", AW'(waiting_o), AW'(1));
        chk("R12 new line", line_addr_o, 48'h6000);

        // random phase
        for (int i = 0; i < 4; i++) lines[i] = {AW'($urandom) << 12} | AW'(i * 64);
        for (int i = 0; i < 3000; i++) begin
            int unsigned r = $urandom % 100;
            arm_vld  = (r < 6);
            arm_vaddr = {16'h0, $urandom};
            wait_vld = ($urandom % 100) < 25;
            wait_paddr = lines[$urandom % 4] + AW'($urandom % 64);
            inv_vld  = ($urandom % 100) < 40;
            case ($urandom % 3)
                0: inv_paddr = m.line;
                1: inv_paddr = lines[$urandom % 4];
                default: inv_paddr = lines[$urandom % 4] + AW'(1 + $urandom % 63);
            endcase
            wake_set = ($urandom % 100) < 8;
            step();
        end

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule